// File: doc/BRIEF.md
# PHY Management Interface Controller

This block lets software talk to an external Ethernet PHY over the two-wire serial management bus (a clock MDC and a bidirectional data line MDIO). Software sets up a single control word that holds the target PHY address, the target register address and one of two command bits: one starts a register write, the other starts a register read. A separate register holds the 16-bit value for writes. Once a command is accepted, the controller produces MDC from the system clock and shifts out one complete management frame. On a read it then returns the PHY's answer in the low half of the same control word. When the frame ends, the command bit clears itself.

Two events can raise an interrupt: the end of a transaction, and a link-change pulse from outside the block. Each event sets a sticky status bit, and software clears that bit by writing a one to it. A mask register with the same bit layout decides which status bits drive `irq`.

The frame engine is a state machine with six states. `ST_IDLE` moves to `ST_PREAMBLE` when a command is accepted. Every other move happens on an MDC falling edge, once the current field has finished: `ST_PREAMBLE` goes to `ST_HEADER` after 32 ones, `ST_HEADER` goes to `ST_TURN` after the start, opcode and address bits, and `ST_TURN` goes to `ST_DATA` after the two turnaround bits. `ST_DATA` goes to `ST_DONE` after 16 data bits. `ST_DONE` lasts one cycle, then returns to `ST_IDLE`.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control, write-data, status and mask registers all read zero, `irq` is low, `mdc` is low and `mdio_oe` is low.
- R2: Writing the control register (select 0) with bit 27 set, while idle, sends a write frame on MDIO, most significant bit first. The frame is 32 ones, then 01, then opcode 01, then PHY address (control bits 20:16), then register address (control bits 25:21), then turnaround 10, then the 16 bits of write-data register bits 15:0 (select 1). `mdio_oe` is high for all 64 bits.
- R3: Writing the control register with only bit 26 set sends 32 ones, 01, opcode 10, PHY address and register address. `mdio_oe` is then low for the final 18 bit times. The 16 bits sampled in the last 16 bit times, MSB first, appear in control bits 15:0 when the read ends.
- R4: MDC has a period of 2*HALF_DIV system clocks while a frame is running and stays low while idle. MDIO changes only when MDC falls, and the block samples MDIO only when MDC rises.
- R5: The command bit (27 or 26) reads back as one while the frame runs and clears itself when the frame ends. The same end of the frame sets status bit 0 (select 2) through a done pulse that lasts one cycle.
- R6: A control-register write that arrives while a command is running is ignored entirely: addresses, command bits and the frame in progress are all left unchanged.
- R7: If bits 27 and 26 are both written as one, the block performs a write and only bit 27 reads back as set.
- R8: A one-cycle pulse on `link_chg` sets status bit 9. Status bits are cleared by writing a one to them. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: `irq` is high exactly when some status bit is set whose mask bit (select 3, bits 0 and 9) is also set.
- R10: The write-data register reads back its bits 15:0. A control write while idle with both command bits zero updates the address fields without starting a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Write target: 0 control, 1 write data, 2 status (write one to clear), 3 mask |
| reg_wdata | input | 32 | Register write value |
| reg_rsel | input | 2 | Read source, same encoding as reg_wsel |
| reg_rdata | output | 32 | Register read value |
| link_chg | input | 1 | Link-change event pulse |
| irq | output | 1 | Interrupt request |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO value from the pad |
| mdio_o | output | 1 | MDIO value to the pad |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
Two events can land in the same cycle. The first is the end of a frame, which sets status bit 0 and clears the command bit. The second is a link-change pulse that arrives together with a software write-one-to-clear of bit 9. The bench counts MDC falling edges to find the frame's last edge, then drives the link pulse and the clear write so they reach the same clock edge as the done pulse. It expects both status bits set afterwards and the command bit clear. A second overlap is a control write issued in the middle of a read. The bench judges it from the address fields and command bit read back during the read, and from the read frame and read data captured once the read has ended.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int PRE_BITS   = 32;
    localparam int ADDR_BITS  = 5;
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = PRE_BITS + 4 + 2 * ADDR_BITS + 2 + DATA_BITS;
    localparam int TURN_FIRST = PRE_BITS + 4 + 2 * ADDR_BITS;
    localparam int DATA_FIRST = TURN_FIRST + 2;

    localparam int CTL_WR_BIT  = 27;
    localparam int CTL_RD_BIT  = 26;
    localparam int CTL_REG_LSB = 21;
    localparam int CTL_PHY_LSB = 16;

    localparam int IRQ_DONE_BIT = 0;
    localparam int IRQ_LINK_BIT = 9;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_WDATA = 2'd1,
        SEL_STAT  = 2'd2,
        SEL_MASK  = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_DONE
    } mgmt_state_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    assign wrap      = run && (cnt == CNT_W'(HALF_DIV - 1));
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the clock rests low whenever no frame runs
    p_mdc_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
    // R4: mdc toggles only on a tick
    p_mdc_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rise_tick && !fall_tick) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 start_rd,
    input  logic [ADDR_BITS-1:0] phy_addr,
    input  logic [ADDR_BITS-1:0] reg_addr,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdio_i,
    output logic                 run,
    output logic                 done,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic [DATA_BITS-1:0] rd_data
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    mgmt_state_e           state, nxt;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] frame;
    logic                  is_rd;
    logic [DATA_BITS-1:0]  cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_tick && bit_cnt == CNT_W'(PRE_BITS - 1))   nxt = ST_HEADER;
            ST_HEADER:   if (fall_tick && bit_cnt == CNT_W'(TURN_FIRST - 1)) nxt = ST_TURN;
            ST_TURN:     if (fall_tick && bit_cnt == CNT_W'(DATA_FIRST - 1)) nxt = ST_DATA;
            ST_DATA:     if (fall_tick && bit_cnt == CNT_W'(FRAME_BITS - 1)) nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            frame   <= '0;
            is_rd   <= 1'b0;
            cap     <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                bit_cnt <= '0;
                is_rd   <= start_rd;
                cap     <= '0;
                frame   <= {{PRE_BITS{1'b1}}, 2'b01,
                            start_rd ? 2'b10 : 2'b01,
                            phy_addr, reg_addr,
                            start_rd ? 2'b00 : 2'b10,
                            start_rd ? {DATA_BITS{1'b0}} : wr_data};
            end else if (fall_tick) begin
                bit_cnt <= bit_cnt + 1'b1;
                frame   <= frame << 1;
            end
            if (rise_tick && is_rd && state == ST_DATA)
                cap <= {cap[DATA_BITS-2:0], mdio_i};
        end
    end

    always_comb begin
        run     = 1'b0;
        done    = 1'b0;
        mdio_oe = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_PREAMBLE: begin run = 1'b1; mdio_oe = 1'b1; end
            ST_HEADER:   begin run = 1'b1; mdio_oe = 1'b1; end
            ST_TURN:     begin run = 1'b1; mdio_oe = !is_rd; end
            ST_DATA:     begin run = 1'b1; mdio_oe = !is_rd; end
            ST_DONE:     done = 1'b1;
            default:     ;
        endcase
        mdio_o  = run ? frame[FRAME_BITS-1] : 1'b0;
        rd_data = cap;
    end

    // R2: a write frame keeps the line driven throughout
    p_write_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !is_rd) |-> mdio_oe);
    // R3: a read releases the line for its data bits
    p_read_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && is_rd) |-> !mdio_oe);
    // R4: the frame moves only on a falling tick
    p_shift_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fall_tick) |=> $stable(frame));
    // R5: done lasts one cycle
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/mdio_irq_unit.sv
module mdio_irq_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done_evt,
    input  logic       link_evt,
    input  logic       clr_we,
    input  logic [1:0] clr_bits,
    input  logic       mask_we,
    input  logic [1:0] mask_bits,
    output logic [1:0] status,
    output logic [1:0] mask,
    output logic       irq
);
    logic [1:0] set_bits;
    logic [1:0] clr_eff;

    assign set_bits = {link_evt, done_evt};
    assign clr_eff  = clr_we ? clr_bits : 2'b00;
    assign irq      = |(status & mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= set_bits | (status & ~clr_eff);
            if (mask_we) mask <= mask_bits;
        end
    end

    // R8: a link event always lands, even against a clear
    p_link_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_evt |=> status[1]);
    // R5: a done pulse always lands in status
    p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> status[0]);
    // R9: no interrupt without an enabled source
    p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != 2'b00));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_wsel,
    input  logic [31:0] reg_wdata,
    input  logic [1:0]  reg_rsel,
    output logic [31:0] reg_rdata,
    input  logic        link_chg,
    output logic        irq,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic                 cmd_wr, cmd_rd, busy;
    logic [ADDR_BITS-1:0] phy_q, regad_q;
    logic [DATA_BITS-1:0] rdata_q, wdata_q, eng_rd;
    logic                 ctrl_wr, accept, start, start_rd;
    logic                 run, done, rise_tick, fall_tick;
    logic [1:0]           status, mask;
    logic                 unused_wbits;

    assign unused_wbits = ^reg_wdata[31:28];
    assign busy     = cmd_wr | cmd_rd;
    assign ctrl_wr  = reg_we && (reg_wsel == SEL_CTRL);
    assign accept   = ctrl_wr && !busy;
    assign start    = accept && (reg_wdata[CTL_WR_BIT] || reg_wdata[CTL_RD_BIT]);
    assign start_rd = !reg_wdata[CTL_WR_BIT] && reg_wdata[CTL_RD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_wr  <= 1'b0;
            cmd_rd  <= 1'b0;
            phy_q   <= '0;
            regad_q <= '0;
            rdata_q <= '0;
            wdata_q <= '0;
        end else begin
            if (accept) begin
                phy_q   <= reg_wdata[CTL_PHY_LSB +: ADDR_BITS];
                regad_q <= reg_wdata[CTL_REG_LSB +: ADDR_BITS];
                cmd_wr  <= reg_wdata[CTL_WR_BIT];
                cmd_rd  <= start_rd;
            end else if (done) begin
                cmd_wr  <= 1'b0;
                cmd_rd  <= 1'b0;
            end
            if (done && cmd_rd) rdata_q <= eng_rd;
            if (reg_we && reg_wsel == SEL_WDATA) wdata_q <= reg_wdata[DATA_BITS-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_rsel))
            SEL_CTRL: begin
                reg_rdata[CTL_WR_BIT] = cmd_wr;
                reg_rdata[CTL_RD_BIT] = cmd_rd;
                reg_rdata[CTL_REG_LSB +: ADDR_BITS] = regad_q;
                reg_rdata[CTL_PHY_LSB +: ADDR_BITS] = phy_q;
                reg_rdata[DATA_BITS-1:0] = rdata_q;
            end
            SEL_WDATA: reg_rdata[DATA_BITS-1:0] = wdata_q;
            SEL_STAT: begin
                reg_rdata[IRQ_DONE_BIT] = status[0];
                reg_rdata[IRQ_LINK_BIT] = status[1];
            end
            SEL_MASK: begin
                reg_rdata[IRQ_DONE_BIT] = mask[0];
                reg_rdata[IRQ_LINK_BIT] = mask[1];
            end
            default: ;
        endcase
    end

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
        .clk(clk), .rst_n(rst_n), .run(run),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
        .phy_addr(reg_wdata[CTL_PHY_LSB +: ADDR_BITS]),
        .reg_addr(reg_wdata[CTL_REG_LSB +: ADDR_BITS]),
        .wr_data(wdata_q), .rise_tick(rise_tick), .fall_tick(fall_tick),
        .mdio_i(mdio_i), .run(run), .done(done), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .rd_data(eng_rd)
    );

    mdio_irq_unit u_irq (
        .clk(clk), .rst_n(rst_n), .done_evt(done), .link_evt(link_chg),
        .clr_we(reg_we && reg_wsel == SEL_STAT),
        .clr_bits({reg_wdata[IRQ_LINK_BIT], reg_wdata[IRQ_DONE_BIT]}),
        .mask_we(reg_we && reg_wsel == SEL_MASK),
        .mask_bits({reg_wdata[IRQ_LINK_BIT], reg_wdata[IRQ_DONE_BIT]}),
        .status(status), .mask(mask), .irq(irq)
    );

    // R7: never both command bits at once
    p_cmd_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wr, cmd_rd}));
    // R6: a control write during a command leaves the addresses alone
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_wr) |=> ($stable(phy_q) && $stable(regad_q)));
    // R5: command bit clears as the frame ends
    p_cmd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;
    localparam int HALF_DIV = 3;
    localparam realtime TCLK = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_wsel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_rsel = 2'd0;
    logic [31:0] reg_rdata;
    logic        link_chg = 1'b0;
    logic        irq, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;

    int          rcnt = 0;
    int          fcnt = 0;
    logic [63:0] cap = '0;
    logic [63:0] oeh = '0;
    logic [15:0] rdval = '0;
    realtime     last_rise = 0.0;
    realtime     period = 0.0;

    always #(TCLK/2) clk = ~clk;

    mdio_mgmt_ctrl #(.HALF_DIV(HALF_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wsel(reg_wsel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .link_chg(link_chg), .irq(irq), .mdc(mdc), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // PHY model: observe on rising, answer on falling
    always @(posedge mdc) begin
        rcnt = rcnt + 1;
        cap  = {cap[62:0], mdio_o};
        oeh  = {oeh[62:0], mdio_oe};
        if (rcnt > 1) period = $realtime - last_rise;
        last_rise = $realtime;
    end
    always @(negedge mdc) begin
        fcnt = fcnt + 1;
        if (fcnt >= 48 && fcnt < 64) mdio_i = rdval[63 - fcnt];
        else                         mdio_i = 1'b1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_wsel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_rsel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic clear_mon();
        rcnt = 0; fcnt = 0; cap = '0; oeh = '0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd_reg(2'd0, v);
            if (v[27:26] == 2'b00) break;
        end
    endtask

    function automatic logic [31:0] ctl(input logic w, input logic r,
                                        input logic [4:0] rg, input logic [4:0] ph);
        return {4'b0, w, r, rg, ph, 16'h0};
    endfunction

    initial begin
        #(TCLK * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [4:0]  phys [4];
        logic [4:0]  regs [4];
        logic [15:0] dats [4];
        phys = '{5'd0, 5'd31, 5'd5, 5'd18};
        regs = '{5'd31, 5'd0, 5'd10, 5'd21};
        dats = '{16'hFFFF, 16'h0000, 16'hA5C3, 16'h1234};

        repeat (3) @(negedge clk);
        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd_reg(2'(s), v);
            check("R1 reg zero", v, 0);
        end
        check("R1 irq/mdc/oe", {irq, mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after release", {irq, mdc, mdio_oe}, 0);

        // R2 write frame sweep
        for (int i = 0; i < 4; i++) begin
            wr_reg(2'd1, {16'hDEAD, dats[i]});
            clear_mon();
            wr_reg(2'd0, ctl(1'b1, 1'b0, regs[i], phys[i]));
            rd_reg(2'd0, v);
            check("R5 write bit while busy", v[27:26], 2'b10);
            wait_idle();
            check("R2 write frame", cap,
                  {32'hFFFFFFFF, 2'b01, 2'b01, phys[i], regs[i], 2'b10, dats[i]});
            check("R2 oe all bits", oeh, 64'hFFFFFFFFFFFFFFFF);
            check("R4 rise count", rcnt, 64);
            check("R4 mdc period", int'(period * 10.0), int'(2 * HALF_DIV * TCLK * 10.0));
            repeat (2 * HALF_DIV + 2) @(negedge clk);
            check("R4 mdc idle low", mdc, 0);
            rd_reg(2'd2, v);
            check("R5 done status", v, 32'h1);
            wr_reg(2'd2, 32'h1);
            rd_reg(2'd2, v);
            check("R8 w1c done", v, 0);
        end

        // R3 read frame sweep
        for (int i = 0; i < 4; i++) begin
            rdval = dats[(i + 2) % 4] ^ 16'h0F0F;
            clear_mon();
            wr_reg(2'd0, ctl(1'b0, 1'b1, regs[i], phys[i]));
            wait_idle();
            check("R3 read header", cap[63:18],
                  {32'hFFFFFFFF, 2'b01, 2'b10, phys[i], regs[i]});
            check("R3 oe pattern", oeh, {{46{1'b1}}, 18'h0});
            rd_reg(2'd0, v);
            check("R3 read data", v, {6'b0, regs[i], phys[i], rdval});
            wr_reg(2'd2, 32'h1);
        end

        // R6 command during read is ignored
        rdval = 16'h3C5A;
        clear_mon();
        wr_reg(2'd0, ctl(1'b0, 1'b1, 5'd7, 5'd9));
        repeat (100) @(negedge clk);
        wr_reg(2'd0, ctl(1'b1, 1'b0, 5'd2, 5'd3));
        rd_reg(2'd0, v);
        check("R6 ctrl during busy", v[31:16], {4'b0, 2'b01, 5'd7, 5'd9});
        wait_idle();
        check("R6 frame untouched", cap[63:18], {32'hFFFFFFFF, 2'b01, 2'b10, 5'd9, 5'd7});
        rd_reg(2'd0, v);
        check("R6 read completed", v, {6'b0, 5'd7, 5'd9, 16'h3C5A});
        check("R6 single frame", rcnt, 64);
        wr_reg(2'd2, 32'h1);

        // R7 both command bits
        wr_reg(2'd1, 32'h0000_8001);
        clear_mon();
        wr_reg(2'd0, ctl(1'b1, 1'b1, 5'd4, 5'd1));
        rd_reg(2'd0, v);
        check("R7 only write bit", v[27:26], 2'b10);
        wait_idle();
        check("R7 write frame", cap, {32'hFFFFFFFF, 4'b0101, 5'd1, 5'd4, 2'b10, 16'h8001});

        // R8 link set; coincident done, link and clear
        wr_reg(2'd2, 32'h1);
        @(negedge clk); link_chg = 1'b1;
        @(negedge clk); link_chg = 1'b0;
        rd_reg(2'd2, v);
        check("R8 link sets", v, 32'h200);
        clear_mon();
        wr_reg(2'd0, ctl(1'b1, 1'b0, 5'd1, 5'd2));
        repeat (64) @(negedge mdc);
        #1;
        link_chg = 1'b1; reg_we = 1'b1; reg_wsel = 2'd2; reg_wdata = 32'h200;
        @(posedge clk); #1;
        link_chg = 1'b0; reg_we = 1'b0;
        rd_reg(2'd2, v);
        check("R8 set beats clear, done too", v, 32'h201);
        rd_reg(2'd0, v);
        check("R5 cmd cleared at same edge", v[27:26], 2'b00);
        wr_reg(2'd2, 32'h200);
        rd_reg(2'd2, v);
        check("R8 w1c link only", v, 32'h1);
        @(negedge clk); link_chg = 1'b1;
        @(negedge clk); link_chg = 1'b0;

        // R9 mask sweep with both status bits set
        for (int m = 0; m < 4; m++) begin
            wr_reg(2'd3, {22'b0, m[1], 8'b0, m[0]});
            rd_reg(2'd3, v);
            check("R9 mask readback", v, {22'b0, m[1], 8'b0, m[0]});
            check("R9 irq both set", irq, (m != 0));
        end
        wr_reg(2'd2, 32'h1);
        for (int m = 0; m < 4; m++) begin
            wr_reg(2'd3, {22'b0, m[1], 8'b0, m[0]});
            check("R9 irq link only", irq, m[1]);
        end

        // R10 readback and address-only control write
        wr_reg(2'd1, 32'hFFFF_BEEF);
        rd_reg(2'd1, v);
        check("R10 wdata readback", v, 32'h0000_BEEF);
        clear_mon();
        wr_reg(2'd0, ctl(1'b0, 1'b0, 5'd19, 5'd23));
        repeat (20) @(negedge clk);
        rd_reg(2'd0, v);
        check("R10 address only", v[31:16], {6'b0, 5'd19, 5'd23});
        check("R10 no frame", rcnt, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule